// File: doc/BRIEF.md
# Standby Entry and Wake-Up Controller

This controller moves a core between normal operation and a low-power standby state. In normal operation both the oscillator enable and the clock-gate enable are high. A sleep request issued while standby is enabled switches the oscillator off and gates the core clock. The controller then waits for the chosen transition on a dedicated non-maskable wake pin.

After the wake edge, the oscillator enable comes back first. The core clock stays gated for a settling interval, counted in clock states and picked by a 3-bit code. The code table is non-monotonic: it runs from 16 states up to 262144 states. The code is captured at the moment standby is entered. When the interval expires, the clock is released and a one-cycle `resumed` pulse is issued.

The edge polarity is read live, so software can enter standby on one edge of the wake pin and leave it on the opposite edge. The block runs on a free-running clock. The wake pin is asynchronous and is brought in through a synchronizer before edge detection.

Top module: `stby_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller returns to normal operation: `osc_en`=1, `clk_run`=1, `resumed`=0, and the settling counter is cleared.
- R2: In normal operation, `sleep_req`=1 together with `stby_en`=1 at a clock edge puts the block into standby. From that edge, `osc_en`=0 and `clk_run`=0.
- R3: In normal operation, `sleep_req`=1 with `stby_en`=0 has no effect: `osc_en` and `clk_run` stay 1 and `resumed` stays 0.
- R4: In standby, the wake edge is selected by `wake_pol`: 0 selects falling and 1 selects rising. A selected edge on `wake_pin` before clock edge k raises `osc_en` after clock edge k+2, while `clk_run` stays 0. The opposite edge leaves the block in standby.
- R5: `wake_pol` is taken live. A value changed after entry decides which edge ends standby.
- R6: After `osc_en` rises, `clk_run` stays 0 for exactly N clock cycles. N depends on the captured code: 0→8192, 1→16384, 2→32768, 3→65536, 4→131072, 5→262144, 6→2048, 7→16.
- R7: `resumed` is high for exactly one cycle: the first cycle in which `clk_run` is 1 again.
- R8: `stab_sel` is captured on the edge that enters standby. Changing it during standby or settling does not change N.
- R9: `sleep_req` during standby or settling is ignored: the block neither leaves standby nor restarts the settling wait.
- R10: Wake-pin edges are ignored in normal operation: `clk_run` stays 1 and `resumed` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep request strobe |
| stby_en | input | 1 | Standby enable; 1 lets a sleep request enter standby |
| stab_sel | input | 3 | Settling-interval code |
| wake_pol | input | 1 | Wake edge select: 0 falling, 1 rising |
| wake_pin | input | 1 | Asynchronous non-maskable wake pin |
| osc_en | output | 1 | Oscillator enable |
| clk_run | output | 1 | Core clock-gate enable (1 = clock running) |
| resumed | output | 1 | One-cycle pulse when the clock is released |

## Verification
Each result has a fixed latency after its stimulus:

- **Entry:** `osc_en` and `clk_run` fall one clock after the sleep request.
- **Wake:** a pin change made before edge k shows up on `osc_en` after edge k+2.
- **Release:** `clk_run` and `resumed` rise N edges after that.

The bench drives inputs on falling edges and samples on falling edges. It checks the last cycle before each change and the first cycle after it, so being one cycle early or one cycle late is caught. N is recomputed in the bench from shifts of the base interval, not from a copied table.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STBY = 2'd1,
    ST_STAB = 2'd2
  } stby_state_e;

  localparam int CNT_W = 19;

  // Settling length in clock states for each select code.
  function automatic logic [CNT_W-1:0] stab_states(input logic [2:0] sel);
    logic [CNT_W-1:0] n;
    case (sel)
      3'd7:    n = CNT_W'(16);
      3'd6:    n = CNT_W'(2048);
      default: n = CNT_W'(8192) << sel;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/stby_wake_sync.sv
module stby_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic pol,
  output logic hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur;
  end

  assign hit = pol ? (cur & ~prev_q) : (~cur & prev_q);

endmodule

// File: rtl/stby_stab_cnt.sv
module stby_stab_cnt #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sleep_req,
  input  logic        stby_en,
  input  logic [2:0]  sel,
  input  logic        wake_hit,
  input  logic        cnt_zero,
  output stby_state_e state,
  output logic [2:0]  sel_q,
  output logic        load,
  output logic        dec,
  output logic        resumed
);
  stby_state_e nxt;
  logic        enter;

  assign enter = (state == ST_RUN) && sleep_req && stby_en;
  assign load  = (state == ST_STBY) && wake_hit;
  assign dec   = (state == ST_STAB) && !cnt_zero;

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:  if (enter)    nxt = ST_STBY;
      ST_STBY: if (wake_hit) nxt = ST_STAB;
      ST_STAB: if (cnt_zero) nxt = ST_RUN;
      default:               nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      sel_q   <= 3'd0;
      resumed <= 1'b0;
    end else begin
      state   <= nxt;
      if (enter) sel_q <= sel;
      resumed <= (state == ST_STAB) && cnt_zero;
    end
  end

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic       stby_en,
  input  logic [2:0] stab_sel,
  input  logic       wake_pol,
  input  logic       wake_pin,
  output logic       osc_en,
  output logic       clk_run,
  output logic       resumed
);
  // Named internal events for the checker.
  stby_state_e      state;
  logic             wake_hit;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;
  logic [2:0]       sel_q;
  logic             cnt_load;
  logic             cnt_dec;
  logic             in_stab;

  stby_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin (wake_pin),
    .pol (wake_pol),
    .hit (wake_hit)
  );

  stby_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .stby_en   (stby_en),
    .sel       (stab_sel),
    .wake_hit  (wake_hit),
    .cnt_zero  (cnt_zero),
    .state     (state),
    .sel_q     (sel_q),
    .load      (cnt_load),
    .dec       (cnt_dec),
    .resumed   (resumed)
  );

  stby_stab_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (stab_states(sel_q) - CNT_W'(1)),
    .dec      (cnt_dec),
    .cnt      (cnt_val),
    .zero     (cnt_zero)
  );

  assign in_stab = (state == ST_STAB);
  assign osc_en  = (state != ST_STBY);
  assign clk_run = (state == ST_RUN);

endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_req,
  input logic             stby_en,
  input logic             osc_en,
  input logic             clk_run,
  input logic             resumed,
  input logic             wake_hit,
  input logic             in_stab,
  input logic [CNT_W-1:0] cnt_val,
  input logic [2:0]       sel_q
);
  AST_ENTER_STANDBY: assert property (@(posedge clk) disable iff (rst)
    (clk_run && sleep_req && stby_en) |=> (!osc_en && !clk_run)); // R2

  AST_NO_ENTRY_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (clk_run && sleep_req && !stby_en) |=> clk_run); // R3

  AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && !wake_hit) |=> !osc_en); // R4

  AST_WAKE_TO_SETTLE: assert property (@(posedge clk) disable iff (rst)
    (!osc_en && wake_hit) |=> (osc_en && !clk_run)); // R4

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (in_stab && cnt_val != '0) |=> (in_stab && (cnt_val + CNT_W'(1)) == $past(cnt_val))); // R6

  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (rst)
    resumed |=> !resumed); // R7

  AST_RESUME_WITH_CLOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_run) |-> resumed); // R7

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (!clk_run && $past(!clk_run)) |-> $stable(sel_q)); // R8

  AST_SLEEP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (in_stab && sleep_req && cnt_val != '0) |=> in_stab); // R9

endmodule

bind stby_ctrl stby_ctrl_chk #(.CNT_W(stby_pkg::CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sleep_req (sleep_req),
  .stby_en   (stby_en),
  .osc_en    (osc_en),
  .clk_run   (clk_run),
  .resumed   (resumed),
  .wake_hit  (wake_hit),
  .in_stab   (in_stab),
  .cnt_val   (cnt_val),
  .sel_q     (sel_q)
);

// File: tb/sim_stby_ctrl.sv
`timescale 1ns/1ps
module sim_stby_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_req = 1'b0;
  logic       stby_en = 1'b0;
  logic [2:0] stab_sel = 3'd0;
  logic       wake_pol = 1'b0;
  logic       wake_pin = 1'b0;
  logic       osc_en, clk_run, resumed;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  stby_ctrl u0 (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .stby_en(stby_en),
    .stab_sel(stab_sel), .wake_pol(wake_pol), .wake_pin(wake_pin),
    .osc_en(osc_en), .clk_run(clk_run), .resumed(resumed)
  );

  // Vector: {stby_en, sel[2:0], pol at entry, pol at exit}
  localparam int NV = 6;
  localparam logic [5:0] VEC [NV] = '{
    {1'b1, 3'd7, 1'b0, 1'b1},
    {1'b1, 3'd7, 1'b1, 1'b0},
    {1'b0, 3'd7, 1'b0, 1'b1},
    {1'b1, 3'd6, 1'b1, 1'b1},
    {1'b1, 3'd0, 1'b0, 1'b0},
    {1'b1, 3'd1, 1'b1, 1'b0}
  };

  function automatic int settle_len(input logic [2:0] c);
    if (c == 3'd7)      return 16;
    else if (c == 3'd6) return 2048;
    else                return 8192 * (1 << c);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enter_sleep(input logic en);
    @(negedge clk);
    stby_en = en; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  // Drive the wake pin, then check the whole wake/settle/release sequence.
  task automatic wake_and_settle(input logic lvl, input int n, input string tag);
    wake_pin = lvl;          // before edge k
    cyc(2);                  // after k+1
    chk(osc_en, 1'b0, {tag, " R4 osc still off"});
    cyc(1);                  // after k+2
    chk(osc_en, 1'b1, {tag, " R4 osc on"});
    chk(clk_run, 1'b0, {tag, " R6 clock gated"});
    cyc(n - 1);
    chk(clk_run, 1'b0, {tag, " R6 last gated cycle"});
    cyc(1);
    chk(clk_run, 1'b1, {tag, " R6 released"});
    chk(resumed, 1'b1, {tag, " R7 pulse"});
    cyc(1);
    chk(resumed, 1'b0, {tag, " R7 pulse ends"});
  endtask

  initial begin : watchdog
    #(4 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    cyc(4);
    rst = 1'b0;
    cyc(1);
    chk(osc_en, 1'b1, "R1 osc after reset");
    chk(clk_run, 1'b1, "R1 clk after reset");
    chk(resumed, 1'b0, "R1 resumed after reset");

    for (int v = 0; v < NV; v++) begin
      logic en, pe, px;
      logic [2:0] s;
      {en, s, pe, px} = VEC[v];
      wake_pol = pe;
      wake_pin = ~px;
      cyc(5);
      stab_sel = s;
      enter_sleep(en);
      if (!en) begin
        chk(clk_run, 1'b1, "R3 no entry clk");
        chk(osc_en, 1'b1, "R3 no entry osc");
        wake_pin = px;
        cyc(6);
        chk(clk_run, 1'b1, "R10 edge in run");
        chk(resumed, 1'b0, "R10 no pulse");
      end else begin
        chk(osc_en, 1'b0, "R2 osc off");
        chk(clk_run, 1'b0, "R2 clk off");
        wake_pol = px;       // R5 polarity changed after entry
        cyc(2);
        wake_and_settle(px, settle_len(s), "R5 vec");
      end
    end

    // R4: the opposite edge is ignored, then the selected one wakes.
    wake_pol = 1'b1; wake_pin = 1'b1; stab_sel = 3'd7;
    cyc(5);
    enter_sleep(1'b1);
    wake_pin = 1'b0;
    cyc(8);
    chk(osc_en, 1'b0, "R4 opposite edge ignored");
    wake_and_settle(1'b1, 16, "R4 rising");

    // R8 and R9: change select and assert sleep while in standby and settling.
    wake_pol = 1'b0; wake_pin = 1'b1; stab_sel = 3'd7;
    cyc(5);
    enter_sleep(1'b1);
    stab_sel = 3'd0;
    sleep_req = 1'b1;
    cyc(3);
    chk(osc_en, 1'b0, "R9 sleep in standby");
    sleep_req = 1'b0;
    wake_pin = 1'b0;
    cyc(3);
    chk(osc_en, 1'b1, "R4 falling wake");
    sleep_req = 1'b1;
    stab_sel = 3'd5;
    cyc(12);
    sleep_req = 1'b0;
    chk(clk_run, 1'b0, "R9 sleep in settle");
    cyc(3);
    chk(clk_run, 1'b0, "R8 last gated cycle");
    cyc(1);
    chk(clk_run, 1'b1, "R8 wait kept at 16");
    chk(resumed, 1'b1, "R8 pulse");

    // R1: reset in the middle of standby.
    stab_sel = 3'd7; wake_pol = 1'b1; wake_pin = 1'b0;
    cyc(5);
    enter_sleep(1'b1);
    chk(osc_en, 1'b0, "R2 in standby before reset");
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    chk(osc_en, 1'b1, "R1 reset leaves standby");
    chk(clk_run, 1'b1, "R1 reset clk");
    chk(resumed, 1'b0, "R1 reset pulse");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule